// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns a set of raw interrupt lines into a vector of pending requests. Each line passes through a synchronizer first. A trigger-mode register then sets how each line is sensed. A line in level mode has a pending bit that simply follows the synchronized input. A line in edge mode has a pending bit that is set when its input goes from low to high and that stays set until downstream acknowledge logic clears it. Each line keeps a remembered copy of its previous synchronized level, and edges are detected against that copy.

The trigger-mode register is written one whole byte at a time. Each write is ANDed with a fixed parameter mask, so lines that must stay edge-sensed cannot be switched to level mode. The stored value can always be read back on a dedicated output. Priority resolution and any processor bus protocol are handled outside this block. The acknowledge logic clears pending requests through a per-line strobe.

Top module: `irq_req_latch`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level) has a pending bit equal to its synchronized input: the bit is set while the input is high and cleared while it is low.
- R2: A line whose trigger-mode bit is 0 (edge) sets its pending bit only when its synchronized input is high and its remembered level is low. An input that stays high does not set the bit again after it has been acknowledged.
- R3: On an edge line, a low input clears only the remembered level. The pending bit stays at 1 until a clear strobe arrives for that line, and the strobe clears it in the next cycle.
- R4: A trigger-mode write stores `mode_wr_data & MODE_MASK` (default mask 8'hFB, so line 2 is always edge-sensed). The stored value appears on `mode_rd_data` one cycle after the write and is held until the next write.
- R5: A clear strobe has no effect on a line in level mode. The pending bit still follows the input.
- R6: On an edge line, if a clear strobe and a new rising edge arrive in the same cycle, the pending bit ends up set.
- R7: Reset clears all pending bits, all remembered levels, all synchronizer stages and the trigger-mode register, so every line starts in edge mode. A line that is held high through reset is treated as a new rising edge once reset is released.
- R8: A change on `line_in` shows on `pend_o` after the third rising clock edge. Two edges are spent in the synchronizer stages and one in the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 8 | Raw interrupt request lines, asynchronous |
| mode_wr_en | input | 1 | Trigger-mode register write strobe |
| mode_wr_data | input | 8 | Trigger-mode write value, 1 = level, 0 = edge |
| mode_rd_data | output | 8 | Stored trigger-mode value |
| ack_clr | input | 8 | Per-line clear strobe from the acknowledge logic |
| pend_o | output | 8 | Pending request vector |

## Verification
If the remembered level on an edge line holds a wrong value, it shows at the ports in one of two ways: a missing pending bit, or an extra pending bit that reappears after an acknowledge. Either shows three cycles after the input change that exposes it. A wrong trigger-mode bit shows on `mode_rd_data` one cycle after the write. It can also show on `pend_o` as a bit that follows the input when it should hold its value, or that holds when it should follow. A reference model in the bench follows every line on every cycle, so any such difference is reported in the cycle it first appears.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic pend;
        logic last;
    } line_state_t;

    // Next state of one request line from its sensing mode, its synchronized
    // input, the clear strobe and its current state.
    function automatic line_state_t line_next(
        input trig_mode_e  mode,
        input logic        in_now,
        input logic        clr,
        input line_state_t cur
    );
        line_state_t nx;
        nx = cur;
        if (mode == TRIG_LEVEL) begin
            nx.pend = in_now;
            nx.last = in_now;
        end else begin
            if (clr) begin
                nx.pend = 1'b0;
            end
            if (in_now && !cur.last) begin
                nx.pend = 1'b1;
            end
            nx.last = in_now;
        end
        return nx;
    endfunction

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
    parameter int N_LINES = 8,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw_i,
    output logic [N_LINES-1:0] sync_o
);
    localparam int LAST_STAGE = STAGES - 1;

    logic [STAGES-1:0][N_LINES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = raw_i;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[LAST_STAGE];
endmodule

// File: rtl/irq_trig_mode_reg.sv
module irq_trig_mode_reg #(
    parameter int                 N_LINES   = 8,
    parameter logic [N_LINES-1:0] MODE_MASK = 8'hFB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_LINES-1:0] wr_data,
    output logic [N_LINES-1:0] mode_o
);
    logic [N_LINES-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d = wr_data & MODE_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core
    import irq_latch_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] sync_i,
    input  logic [N_LINES-1:0] mode_i,
    input  logic [N_LINES-1:0] clr_i,
    output logic [N_LINES-1:0] pend_o,
    output logic [N_LINES-1:0] last_o
);
    line_state_t [N_LINES-1:0] st_d, st_q;

    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            st_d[i] = line_next(trig_mode_e'(mode_i[i]), sync_i[i], clr_i[i], st_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_out
        assign pend_o[g] = st_q[g].pend;
        assign last_o[g] = st_q[g].last;
    end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int           N_LINES     = 8,
    parameter int           SYNC_STAGES = 2,
    parameter logic [N_LINES-1:0] MODE_MASK = 8'hFB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic               mode_wr_en,
    input  logic [N_LINES-1:0] mode_wr_data,
    output logic [N_LINES-1:0] mode_rd_data,
    input  logic [N_LINES-1:0] ack_clr,
    output logic [N_LINES-1:0] pend_o
);
    logic [N_LINES-1:0] sync_w;
    logic [N_LINES-1:0] mode_w;
    logic [N_LINES-1:0] last_w;

    irq_sync_chain #(
        .N_LINES (N_LINES),
        .STAGES  (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (line_in),
        .sync_o (sync_w)
    );

    irq_trig_mode_reg #(
        .N_LINES   (N_LINES),
        .MODE_MASK (MODE_MASK)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode_o  (mode_w)
    );

    irq_pend_core #(
        .N_LINES (N_LINES)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_w),
        .mode_i (mode_w),
        .clr_i  (ack_clr),
        .pend_o (pend_o),
        .last_o (last_w)
    );

    assign mode_rd_data = mode_w;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
    parameter int                 N_LINES   = 8,
    parameter logic [N_LINES-1:0] MODE_MASK = 8'hFB
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [N_LINES-1:0] wr_data,
    input logic [N_LINES-1:0] mode,
    input logic [N_LINES-1:0] sync,
    input logic [N_LINES-1:0] last,
    input logic [N_LINES-1:0] ack,
    input logic [N_LINES-1:0] pend
);
    // R4
    mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode & ~MODE_MASK) == '0);

    // R4
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mode == ($past(wr_data) & MODE_MASK));

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        // R1
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode[i] |=> pend[i] == $past(sync[i]));

        // R2
        edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode[i] && !pend[i]) |=> (!pend[i] || $past(sync[i] && !last[i])));

        // R3
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode[i] && pend[i] && !ack[i]) |=> pend[i]);

        // R5
        level_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] && ack[i] && sync[i]) |=> pend[i]);

        // R6
        ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode[i] && ack[i] && sync[i] && !last[i]) |=> pend[i]);
    end
endmodule

bind irq_req_latch irq_req_latch_chk #(
    .N_LINES   (N_LINES),
    .MODE_MASK (MODE_MASK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr_en),
    .wr_data (mode_wr_data),
    .mode    (mode_rd_data),
    .sync    (sync_w),
    .last    (last_w),
    .ack     (ack_clr),
    .pend    (pend_o)
);

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;
    localparam int             N          = 8;
    localparam logic [N-1:0]   MASK       = 8'hFB;
    localparam time            CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] line_in = '0;
    logic         mode_wr_en = 1'b0;
    logic [N-1:0] mode_wr_data = '0;
    logic [N-1:0] mode_rd_data;
    logic [N-1:0] ack_clr = '0;
    logic [N-1:0] pend_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [N-1:0] m_pend = '0, m_last = '0, m_mode = '0, m_s1 = '0, m_s2 = '0;
    logic [15:0]  lf = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_req_latch u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_in      (line_in),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .mode_rd_data (mode_rd_data),
        .ack_clr      (ack_clr),
        .pend_o       (pend_o)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Reference behaviour taken from the requirements, one clock edge.
    task automatic model_step();
        for (int i = 0; i < N; i++) begin
            if (m_mode[i]) begin
                m_pend[i] = m_s2[i];
            end else begin
                if (ack_clr[i]) m_pend[i] = 1'b0;
                if (m_s2[i] && !m_last[i]) m_pend[i] = 1'b1;
            end
            m_last[i] = m_s2[i];
        end
        m_s2 = m_s1;
        m_s1 = line_in;
        if (mode_wr_en) m_mode = mode_wr_data & MASK;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R1 level lines", pend_o & m_mode, m_pend & m_mode);
        check("R2 edge lines", pend_o & ~m_mode, m_pend & ~m_mode);
        check("R4 mode readback", mode_rd_data, m_mode);
    endtask

    task automatic lf_next();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R7: reset state, with line 5 held high through reset
        line_in = 8'h20;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 pend after reset", pend_o, 8'h00);
        check("R7 mode after reset", mode_rd_data, 8'h00);
        rst_n = 1'b1;
        tick();
        tick();
        check("R8 not yet visible", pend_o, 8'h00);
        tick();
        check("R7 held-high line seen as edge", pend_o, 8'h20);

        line_in = '0;
        ack_clr = 8'h20;
        tick();
        ack_clr = '0;
        repeat (3) tick();
        check("R3 cleared by strobe", pend_o, 8'h00);

        // R8: three edges of latency on line 0
        line_in = 8'h01;
        tick();
        tick();
        check("R8 two edges", pend_o, 8'h00);
        tick();
        check("R8 three edges", pend_o, 8'h01);

        // R3: low input does not clear an edge request
        line_in = 8'h00;
        repeat (4) tick();
        check("R3 held after low", pend_o, 8'h01);
        ack_clr = 8'h01;
        tick();
        ack_clr = '0;
        check("R3 strobe clears", pend_o, 8'h00);

        // R2: held-high input does not retrigger after acknowledge
        line_in = 8'h01;
        repeat (3) tick();
        check("R2 set by edge", pend_o, 8'h01);
        ack_clr = 8'h01;
        tick();
        ack_clr = '0;
        repeat (3) tick();
        check("R2 no retrigger while high", pend_o, 8'h00);

        // R6: clear strobe together with a new edge
        line_in = 8'h00;
        repeat (3) tick();
        line_in = 8'h01;
        tick();
        tick();
        ack_clr = 8'h01;
        tick();
        ack_clr = '0;
        check("R6 edge wins over strobe", pend_o, 8'h01);
        ack_clr = 8'h01;
        tick();
        ack_clr = '0;
        line_in = 8'h00;
        repeat (3) tick();

        // R4: every write value
        for (int v = 0; v < 256; v++) begin
            mode_wr_en   = 1'b1;
            mode_wr_data = v[7:0];
            tick();
            check("R4 masked write", mode_rd_data, v[7:0] & MASK);
        end
        mode_wr_en = 1'b0;
        tick();
        check("R4 value held", mode_rd_data, 8'hFF & MASK);

        // R5: strobes on level lines have no effect
        line_in = 8'hFF;
        ack_clr = 8'hFF;
        repeat (4) tick();
        check("R5 level lines ignore strobe", pend_o & MASK, MASK);
        line_in = 8'h00;
        repeat (4) tick();
        check("R1 level lines drop", pend_o & MASK, 8'h00);
        ack_clr = '0;

        // Mixed sweep under several mode patterns
        for (int p = 0; p < 6; p++) begin
            mode_wr_en = 1'b1;
            case (p)
                0: mode_wr_data = 8'h00;
                1: mode_wr_data = 8'hFF;
                2: mode_wr_data = 8'hAA;
                3: mode_wr_data = 8'h55;
                4: mode_wr_data = 8'h0F;
                default: mode_wr_data = 8'hF0;
            endcase
            tick();
            mode_wr_en = 1'b0;
            for (int c = 0; c < 250; c++) begin
                lf_next();
                line_in = lf[7:0];
                ack_clr = lf[15:8] & lf[11:4];
                tick();
            end
            ack_clr = '0;
        end

        finish_run();
    end
endmodule